// File: doc/BRIEF.md
# Host Bus Pacing Controller

This block sits between a fast local processor core and a slow legacy host bus. Every core bus cycle is classified by address through a small programmable region table. The three outcomes are: served locally at full core speed, carried out on the host bus in step with the host clock, or posted to the host as a video write-through. Local accesses complete in the cycle they are presented. Host accesses hold the core until a host bus cycle has run. Video reads stay local. Video writes enter a short FIFO that drains to the host while the core keeps running.

A drive-motor flag is set and cleared by core writes to two fixed control addresses. While it is set, the block paces every core access to the host clock, so software timing loops keep their original speed. The host clock comes in asynchronously. It passes through a synchroniser, and its rising edges are detected in the fast domain. Each detected edge both ends the host bus cycle in flight and may start the next one.

Top module: `host_bus_pacer`

## Requirements
- R1: With the motor flag clear, a core access whose class is local (code 0, reserved code 3, or an address no enabled entry matches) completes with coreStall low in the cycle it is presented.
- R2: The class of an address is taken from the lowest-numbered enabled region entry for which (address AND mask) equals base. If no enabled entry matches, the access is local. A configuration write (cfgWe high) replaces entry cfgIdx from the next cycle on.
- R3: A host-class access (code 1) stalls the core. It is launched on the first detected host edge at which the write FIFO is empty and no earlier core host cycle is still in flight. It completes, with coreStall low, on the next detected edge. On that completion cycle a read returns hostRdata on coreRdata. On every other cycle coreRdata is zero.
- R4: With the motor flag clear, a read of a video-class address (code 2) completes without stall.
- R5: A video-class write is posted to the FIFO and completes without stall unless the FIFO already holds QDEPTH entries. In that case it stalls until an entry has drained. The FIFO never holds more than QDEPTH entries.
- R6: On each detected host edge, a non-empty FIFO launches its oldest entry as a host write, and it takes priority over any core host access. Entries leave in the order they were posted.
- R7: While the motor flag is set, every core access, whatever its class, completes only in a cycle in which a host edge is detected. A video write additionally still needs FIFO space.
- R8: The motor flag is clear after reset. A completed core write to MOTOR_ON_ADDR sets it, and a completed core write to MOTOR_OFF_ADDR clears it. Reads of either address leave it unchanged.
- R9: A rising edge of hostClk is seen by two synchroniser flops and compared against a third flop. hostStrobe, hostWe, hostAddr and hostWdata change only in the cycle after a detected edge. A launched host cycle keeps hostStrobe high until the next detected edge.
- R10: During and directly after reset, coreStall is low with no request, hostStrobe is low, and hostAddr, hostWdata and coreRdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Region table write strobe |
| cfgIdx | input | IDX_W | Region entry to write |
| cfgEnable | input | 1 | Entry enable bit |
| cfgBase | input | ADDR_W | Entry base address |
| cfgMask | input | ADDR_W | Entry compare mask |
| cfgClass | input | 2 | Entry class: 0 local, 1 host, 2 video, 3 local |
| coreReq | input | 1 | Core bus cycle request, held while stalled |
| coreWe | input | 1 | Core write when high |
| coreAddr | input | ADDR_W | Core address |
| coreWdata | input | DATA_W | Core write data |
| coreStall | output | 1 | Holds the core; the access completes when low with coreReq high |
| coreRdata | output | DATA_W | Host read data on a host read completion, else zero |
| hostClk | input | 1 | Asynchronous legacy host clock |
| hostStrobe | output | 1 | Host bus cycle in progress |
| hostWe | output | 1 | Host bus cycle is a write |
| hostAddr | output | ADDR_W | Host bus address |
| hostWdata | output | DATA_W | Host bus write data |
| hostRdata | input | DATA_W | Host bus read data |

## Verification
The bench builds the block with a two-entry FIFO and four region entries. With a FIFO that shallow, a burst of three video writes fills it and forces the stall path. A host read issued directly behind such a burst has to wait behind queued drains. Four entries are enough for overlapping regions, so both lowest-index priority and re-programming an entry can be checked. The host clock's high and low times are changed between phases, down to a single fast cycle, so edge detection is exercised at both fast and slow host rates.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic [1:0] {
    CLS_LOCAL = 2'd0,
    CLS_HOST  = 2'd1,
    CLS_VIDEO = 2'd2,
    CLS_RSVD  = 2'd3
  } regionClass_t;

  typedef struct packed {
    logic qPush;
    logic qPop;
    logic launchCore;
    logic motorSet;
    logic motorClr;
    logic readDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseEdge
);

  logic [STAGES-1:0] chain;
  logic              prevLevel;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= chain[STAGES-1];
  end

  assign riseEdge = chain[STAGES-1] & ~prevLevel;

endmodule

// File: rtl/hbp_datapath.sv
module hbp_datapath
  import hbp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int REGIONS = 4,
  parameter int QDEPTH  = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 3,
  parameter int PTR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic [1:0]        cfgClass,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] hostRdata,
  output regionClass_t      regionCls,
  output logic              qEmpty,
  output logic              qFull,
  output logic [CNT_W-1:0]  qCount,
  output logic              motorOn,
  output logic              hostWe,
  output logic [ADDR_W-1:0] hostAddr,
  output logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] coreRdata
);

  // Region table
  logic                regEn   [REGIONS];
  logic [ADDR_W-1:0]   regBase [REGIONS];
  logic [ADDR_W-1:0]   regMask [REGIONS];
  regionClass_t        regCls  [REGIONS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REGIONS; i++) begin
        regEn[i]   <= 1'b0;
        regBase[i] <= '0;
        regMask[i] <= '0;
        regCls[i]  <= CLS_LOCAL;
      end
    end else if (cfgWe) begin
      regEn[cfgIdx]   <= cfgEnable;
      regBase[cfgIdx] <= cfgBase;
      regMask[cfgIdx] <= cfgMask;
      regCls[cfgIdx]  <= regionClass_t'(cfgClass);
    end
  end

  // Lowest index wins: scan from the top so lower entries overwrite.
  always_comb begin
    regionCls = CLS_LOCAL;
    for (int i = REGIONS - 1; i >= 0; i--) begin
      if (regEn[i] && ((coreAddr & regMask[i]) == regBase[i]))
        regionCls = regCls[i];
    end
  end

  // Posted write FIFO
  logic [ADDR_W-1:0] qAddrMem [QDEPTH];
  logic [DATA_W-1:0] qDataMem [QDEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  assign qEmpty = (qCount == '0);
  assign qFull  = (qCount == CNT_W'(QDEPTH));

  always_ff @(posedge clk) begin
    if (strb.qPush) begin
      qAddrMem[wrPtr] <= coreAddr;
      qDataMem[wrPtr] <= coreWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strb.qPush) wrPtr <= wrPtr + 1'b1;
      if (strb.qPop)  rdPtr <= rdPtr + 1'b1;
      case ({strb.qPush, strb.qPop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // Host bus address/data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostWe    <= 1'b0;
      hostAddr  <= '0;
      hostWdata <= '0;
    end else if (strb.qPop) begin
      hostWe    <= 1'b1;
      hostAddr  <= qAddrMem[rdPtr];
      hostWdata <= qDataMem[rdPtr];
    end else if (strb.launchCore) begin
      hostWe    <= coreWe;
      hostAddr  <= coreAddr;
      hostWdata <= coreWdata;
    end
  end

  // Drive-motor flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              motorOn <= 1'b0;
    else if (strb.motorSet) motorOn <= 1'b1;
    else if (strb.motorClr) motorOn <= 1'b0;
  end

  assign coreRdata = strb.readDone ? hostRdata : '0;

endmodule

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
  import hbp_pkg::*;
#(
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] MOTOR_ON_ADDR  = 16'hE011,
  parameter logic [15:0] MOTOR_OFF_ADDR = 16'hE010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  regionClass_t      regionCls,
  input  logic              qEmpty,
  input  logic              qFull,
  input  logic              motorOn,
  input  logic              hostEdge,
  output logic              coreStall,
  output logic              hostStrobe,
  output ctrlStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] ON_A  = ADDR_W'(MOTOR_ON_ADDR);
  localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(MOTOR_OFF_ADDR);

  logic txnCore;
  logic paceOk;
  logic canFinish;
  logic finishNow;
  logic coreOwnsBus;

  assign paceOk      = !motorOn || hostEdge;
  assign coreOwnsBus = hostStrobe && txnCore;

  always_comb begin
    case (regionCls)
      CLS_HOST:  canFinish = hostEdge && coreOwnsBus;
      CLS_VIDEO: canFinish = coreWe ? (paceOk && !qFull) : paceOk;
      default:   canFinish = paceOk;
    endcase
  end

  assign finishNow = coreReq && canFinish;
  assign coreStall = coreReq && !canFinish;

  always_comb begin
    strb            = '0;
    strb.qPush      = finishNow && (regionCls == CLS_VIDEO) && coreWe;
    strb.qPop       = hostEdge && !qEmpty;
    strb.launchCore = hostEdge && qEmpty && coreReq &&
                      (regionCls == CLS_HOST) && !coreOwnsBus;
    strb.motorSet   = finishNow && coreWe && (coreAddr == ON_A);
    strb.motorClr   = finishNow && coreWe && (coreAddr == OFF_A) &&
                      (coreAddr != ON_A);
    strb.readDone   = finishNow && (regionCls == CLS_HOST) && !coreWe;
  end

  // One host bus cycle spans one host clock period, edge to edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostStrobe <= 1'b0;
      txnCore    <= 1'b0;
    end else if (hostEdge) begin
      hostStrobe <= strb.qPop || strb.launchCore;
      txnCore    <= strb.launchCore;
    end
  end

endmodule

// File: rtl/host_bus_pacer.sv
module host_bus_pacer
  import hbp_pkg::*;
#(
  parameter int          ADDR_W         = 16,
  parameter int          DATA_W         = 8,
  parameter int          NUM_REGIONS    = 4,
  parameter int          QDEPTH         = 4,
  parameter int          SYNC_STAGES    = 2,
  parameter logic [15:0] MOTOR_ON_ADDR  = 16'hE011,
  parameter logic [15:0] MOTOR_OFF_ADDR = 16'hE010,
  localparam int         IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic [1:0]        cfgClass,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic              coreStall,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              hostClk,
  output logic              hostStrobe,
  output logic              hostWe,
  output logic [ADDR_W-1:0] hostAddr,
  output logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] hostRdata
);

  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic         hostEdge;
  regionClass_t regionCls;
  logic         qEmpty;
  logic         qFull;
  logic [CNT_W-1:0] qCount;
  logic         motorOn;
  ctrlStrobes_t strb;

  hbp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (hostClk),
    .riseEdge (hostEdge)
  );

  hbp_ctrl #(
    .ADDR_W         (ADDR_W),
    .MOTOR_ON_ADDR  (MOTOR_ON_ADDR),
    .MOTOR_OFF_ADDR (MOTOR_OFF_ADDR)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .coreReq    (coreReq),
    .coreWe     (coreWe),
    .coreAddr   (coreAddr),
    .regionCls  (regionCls),
    .qEmpty     (qEmpty),
    .qFull      (qFull),
    .motorOn    (motorOn),
    .hostEdge   (hostEdge),
    .coreStall  (coreStall),
    .hostStrobe (hostStrobe),
    .strb       (strb)
  );

  hbp_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REGIONS (NUM_REGIONS),
    .QDEPTH  (QDEPTH),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .PTR_W   (PTR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgIdx    (cfgIdx),
    .cfgEnable (cfgEnable),
    .cfgBase   (cfgBase),
    .cfgMask   (cfgMask),
    .cfgClass  (cfgClass),
    .coreWe    (coreWe),
    .coreAddr  (coreAddr),
    .coreWdata (coreWdata),
    .strb      (strb),
    .hostRdata (hostRdata),
    .regionCls (regionCls),
    .qEmpty    (qEmpty),
    .qFull     (qFull),
    .qCount    (qCount),
    .motorOn   (motorOn),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .coreRdata (coreRdata)
  );

endmodule

// File: rtl/hbp_checker.sv
module hbp_checker
  import hbp_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             coreReq,
  input logic             coreWe,
  input logic             coreStall,
  input logic             hostStrobe,
  input logic             hostEdge,
  input regionClass_t     regionCls,
  input logic             qEmpty,
  input logic [CNT_W-1:0] qCount,
  input logic             motorOn
);

  a_r1_local_fast: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && regionCls == CLS_LOCAL && !motorOn) |-> !coreStall);

  a_r4_video_read_fast: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && regionCls == CLS_VIDEO && !coreWe && !motorOn) |-> !coreStall);

  a_r5_queue_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(QDEPTH));

  a_r3_host_done_at_edge: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && regionCls == CLS_HOST && !coreStall) |-> (hostEdge && hostStrobe));

  a_r3_read_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && regionCls == CLS_HOST && !coreWe && !coreStall) |-> qEmpty);

  a_r7_throttle: assert property (@(posedge clk) disable iff (!rstN)
    (motorOn && coreReq && !coreStall) |-> hostEdge);

  a_r8_motor_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(motorOn) |-> $past(coreReq && coreWe && !coreStall));

  a_r9_strobe_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hostStrobe) |-> $past(hostEdge));

endmodule

bind host_bus_pacer hbp_checker #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .coreReq    (coreReq),
  .coreWe     (coreWe),
  .coreStall  (coreStall),
  .hostStrobe (hostStrobe),
  .hostEdge   (hostEdge),
  .regionCls  (regionCls),
  .qEmpty     (qEmpty),
  .qCount     (qCount),
  .motorOn    (motorOn)
);

// File: tb/sim_host_bus_pacer.sv
module sim_host_bus_pacer;

  localparam int QD = 2;
  localparam logic [15:0] M_ON  = 16'hE011;
  localparam logic [15:0] M_OFF = 16'hE010;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic        cfgEnable = 1'b0;
  logic [15:0] cfgBase = '0;
  logic [15:0] cfgMask = '0;
  logic [1:0]  cfgClass = '0;
  logic        coreReq = 1'b0;
  logic        coreWe = 1'b0;
  logic [15:0] coreAddr = '0;
  logic [7:0]  coreWdata = '0;
  logic        coreStall;
  logic [7:0]  coreRdata;
  logic        hostClk = 1'b0;
  logic        hostStrobe;
  logic        hostWe;
  logic [15:0] hostAddr;
  logic [7:0]  hostWdata;
  logic [7:0]  hostRdata;

  assign hostRdata = hostAddr[7:0] ^ 8'h5A;

  host_bus_pacer #(.NUM_REGIONS(4), .QDEPTH(QD)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgEnable(cfgEnable), .cfgBase(cfgBase), .cfgMask(cfgMask),
    .cfgClass(cfgClass), .coreReq(coreReq), .coreWe(coreWe),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .coreStall(coreStall),
    .coreRdata(coreRdata), .hostClk(hostClk), .hostStrobe(hostStrobe),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic        tEn [4];
  logic [15:0] tBase [4];
  logic [15:0] tMask [4];
  logic [1:0]  tCls [4];
  logic [23:0] mq[$];
  logic        s1 = 0, s2 = 0, s3 = 0;
  logic        mMotor = 0, mActive = 0, mCore = 0;
  logic        mBusWe = 0;
  logic [15:0] mBusAddr = '0;
  logic [7:0]  mBusData = '0;
  logic        mEdge, mDone, mStall, mDoneSeen = 0;
  logic [1:0]  mClsNow;
  logic [7:0]  mRdata;

  initial for (int i = 0; i < 4; i++) begin
    tEn[i] = 0; tBase[i] = 0; tMask[i] = 0; tCls[i] = 0;
  end

  function automatic logic [1:0] lookup(input logic [15:0] a);
    for (int i = 0; i < 4; i++)
      if (tEn[i] && ((a & tMask[i]) == tBase[i])) return tCls[i];
    return 2'd0;
  endfunction

  function automatic void evalModel();
    logic pace;
    mEdge   = s2 && !s3;
    mClsNow = lookup(coreAddr);
    pace    = !mMotor || mEdge;
    case (mClsNow)
      2'd1:    mDone = mEdge && mActive && mCore;
      2'd2:    mDone = coreWe ? (pace && mq.size() < QD) : pace;
      default: mDone = pace;
    endcase
    mDone  = mDone && coreReq;
    mStall = coreReq && !mDone;
    mRdata = (mDone && mClsNow == 2'd1 && !coreWe) ? (mBusAddr[7:0] ^ 8'h5A) : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        tEn[i] = 0; tBase[i] = 0; tMask[i] = 0; tCls[i] = 0;
      end
      mq.delete();
      s1 = 0; s2 = 0; s3 = 0;
      mMotor = 0; mActive = 0; mCore = 0;
      mBusWe = 0; mBusAddr = 0; mBusData = 0; mDoneSeen = 0;
    end else begin
      int qn;
      logic doPush, nAct, nCore;
      evalModel();
      qn = mq.size();
      doPush = mDone && mClsNow == 2'd2 && coreWe;
      if (mDone && coreWe && coreAddr == M_ON) mMotor = 1;
      else if (mDone && coreWe && coreAddr == M_OFF) mMotor = 0;
      if (mEdge) begin
        nAct = 0; nCore = 0;
        if (qn != 0) begin
          logic [23:0] it;
          it = mq.pop_front();
          mBusWe = 1; mBusAddr = it[23:8]; mBusData = it[7:0]; nAct = 1;
        end else if (coreReq && mClsNow == 2'd1 && !(mActive && mCore)) begin
          mBusWe = coreWe; mBusAddr = coreAddr; mBusData = coreWdata;
          nAct = 1; nCore = 1;
        end
        mActive = nAct; mCore = nCore;
      end
      if (doPush) mq.push_back({coreAddr, coreWdata});
      if (cfgWe) begin
        tEn[cfgIdx] = cfgEnable; tBase[cfgIdx] = cfgBase;
        tMask[cfgIdx] = cfgMask; tCls[cfgIdx] = cfgClass;
      end
      s3 = s2; s2 = s1; s1 = hostClk;
      mDoneSeen = mDone;
    end
  end

  // ---------------- comparison ----------------
  int    nCmp = 0, nBad = 0, cycles = 0;
  string curTag = "R10";
  logic  started = 0;

  task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %h expected %h", curTag, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      evalModel();
      chk("coreStall",  32'(coreStall),  32'(mStall));
      chk("coreRdata",  32'(coreRdata),  32'(mRdata));
      chk("hostStrobe", 32'(hostStrobe), 32'(mActive));
      chk("hostWe",     32'(hostWe),     32'(mBusWe));
      chk("hostAddr",   32'(hostAddr),   32'(mBusAddr));
      chk("hostWdata",  32'(hostWdata),  32'(mBusData));
    end
    if (cycles > 100000) begin
      nBad++;
      $display("FAIL watchdog %s: got %0d cycles expected fewer", curTag, cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  // ---------------- host clock ----------------
  int hiLen = 3, loLen = 4;
  initial begin
    forever begin
      repeat (loLen) @(negedge clk);
      #1 hostClk = 1'b1;
      repeat (hiLen) @(negedge clk);
      #1 hostClk = 1'b0;
    end
  end

  // ---------------- stimulus tasks (start and end at a negedge) ----------------
  task automatic cfg(input int idx, input logic en, input logic [15:0] b,
                     input logic [15:0] m, input logic [1:0] c);
    #1 cfgWe = 1; cfgIdx = 2'(idx); cfgEnable = en; cfgBase = b; cfgMask = m; cfgClass = c;
    coreReq = 0;
    @(negedge clk);
    #1 cfgWe = 0;
    @(negedge clk);
  endtask

  task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d);
    #1 coreReq = 1; coreAddr = a; coreWe = w; coreWdata = d;
    do @(negedge clk); while (!mDoneSeen);
  endtask

  task automatic idle(input int n);
    #1 coreReq = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    started = 1;
    curTag = "R10";
    repeat (4) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk);
    idle(3);

    curTag = "R2";
    cfg(0, 1, 16'hE010, 16'hFFFE, 2'd1);   // drive control pair: host
    cfg(1, 1, 16'h0400, 16'hFC00, 2'd2);   // video window
    cfg(2, 1, 16'hE000, 16'hF000, 2'd1);   // host I/O page
    cfg(3, 1, 16'h8000, 16'hC000, 2'd3);   // reserved code: local

    curTag = "R1";
    access(16'h1234, 0, 8'h00);
    access(16'h2000, 1, 8'h11);
    access(16'h8123, 0, 8'h00);
    access(16'hF000, 1, 8'h22);
    idle(2);

    curTag = "R4";
    access(16'h0400, 0, 8'h00);
    access(16'h07FF, 0, 8'h00);
    idle(2);

    curTag = "R5";
    for (int k = 0; k < 5; k++) access(16'h0410 + 16'(k), 1, 8'hA0 + 8'(k));
    curTag = "R6";
    access(16'h0500, 1, 8'h77);
    access(16'h0501, 1, 8'h78);
    curTag = "R3";
    access(16'hE100, 0, 8'h00);
    access(16'hE200, 1, 8'h5C);
    access(16'hE300, 0, 8'h00);
    idle(10);

    curTag = "R8";
    access(M_ON, 0, 8'h00);      // read leaves flag clear
    access(16'h1000, 0, 8'h00);
    access(M_ON, 1, 8'h01);
    curTag = "R7";
    access(16'h1000, 0, 8'h00);
    access(16'h1001, 1, 8'h02);
    access(16'h0420, 0, 8'h00);
    access(16'h0421, 1, 8'h03);
    access(16'h0422, 1, 8'h04);
    access(16'h0423, 1, 8'h05);
    access(16'hE400, 0, 8'h00);
    curTag = "R8";
    access(M_OFF, 1, 8'h00);
    access(16'h1002, 0, 8'h00);
    idle(6);

    curTag = "R2";
    cfg(3, 1, 16'h0400, 16'hFF00, 2'd1);   // overlaps entry 1, loses
    access(16'h0450, 0, 8'h00);
    cfg(1, 0, 16'h0400, 16'hFC00, 2'd2);   // disable entry 1
    access(16'h0450, 0, 8'h00);
    access(16'h0451, 1, 8'h44);
    access(16'h0600, 0, 8'h00);             // no match now: local
    idle(6);

    curTag = "R9";
    hiLen = 1; loLen = 1;
    repeat (8) @(negedge clk);
    access(16'hE010, 0, 8'h00);
    for (int k = 0; k < 3; k++) access(16'h0700 + 16'(k), 1, 8'h30 + 8'(k));
    access(16'hE020, 0, 8'h00);
    hiLen = 9; loLen = 13;
    idle(30);
    access(16'hE021, 1, 8'h99);
    access(16'h0702, 1, 8'h3F);
    access(16'hE022, 0, 8'h00);
    idle(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule